// File: doc/BRIEF.md
# Nibble-Prefix Accumulator Processor Core

This block is a 32-bit processor core that completes one instruction per clock. Every instruction is a single byte. The upper nibble selects the operation and the lower nibble is a small immediate. Larger constants and offsets are built up over several bytes: prefix instructions shift the partial value into an operand register, and the next non-prefix instruction consumes it. The architectural state is a program counter, the operand register and two working registers, A and B. Arithmetic, stores and conditional branches all centre on A.

The core has two memory ports that work in the same cycle:
- a byte-addressed instruction fetch port, which returns a byte combinationally;
- a word-addressed data port, which does one combinational read or one write per clock.

The memories themselves sit outside the block, and so does any service routine. A supervisor call raises a one-cycle halt strobe that carries the value of A. It then stops the core until the next reset.

Top module: `nib_core`

## Requirements
- R1: While reset is low, the program counter, the operand register, A and B are zero, `fetchEn` is high, and `fetchAddr` is 0. After reset is released, the first instruction executes from byte address 0.
- R2: Bits 7:4 of a fetched byte are the opcode and bits 3:0 are the immediate. The opcodes are: 0 load A absolute, 1 load B absolute, 2 store A absolute, 3 load A constant, 4 load B constant, 5 load A pc-relative, 6 load A indexed, 7 load B indexed, 8 store A indexed, 9 branch, A branch if zero, B branch if negative, C no-op, D operate, E positive prefix, F negative prefix. Each instruction takes one clock, and any instruction that does not branch advances the pc by exactly 1.
- R3: The operand is the operand register ORed with the zero-extended immediate. A positive prefix loads the operand register with the operand shifted left 4 bits. A negative prefix loads it with 0xFFFFFF00 ORed with the operand shifted left 4 bits. Prefixes chain.
- R4: Every non-prefix instruction clears the operand register, so the next instruction starts from its own immediate.
- R5: Opcode 3 loads A with the operand and opcode 4 loads B with it. Opcode 5 loads A with the pc of the next byte plus the operand.
- R6: Opcodes 0, 1 and 2 use the operand as a word address on the data port, so data address 1 names bytes 4 to 7.
- R7: Opcode 6 reads from address A plus operand into A. Opcode 7 reads from B plus operand into B. Opcode 8 writes A to B plus operand.
- R8: Opcode 9 sets the pc to the pc of the next byte plus the operand. Opcode A does the same only when A is zero, and opcode B only when bit 31 of A is set. Negative operands branch backwards.
- R9: Opcode D acts on the full operand value: 0 sets the pc to B, 1 sets A to A+B, 2 sets A to A−B, and 3 is a supervisor call. Every other operand value, and opcode C, changes nothing except the pc and the operand register.
- R10: A supervisor call drives `haltValid` high for exactly one cycle, with `haltCode` equal to A.
- R11: After a supervisor call, `fetchEn` is low, `fetchAddr` stays fixed, and no write or halt strobe appears until reset.
- R12: `dataWe` is high only for opcodes 2 and 8, and `dataWdata` is A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchEn | output | 1 | High while the core is fetching; low once halted |
| fetchAddr | output | 32 | Byte address of the current instruction (the pc) |
| fetchByte | input | 8 | Instruction byte at `fetchAddr`, combinational |
| dataAddr | output | 32 | Word address for the data port |
| dataRdata | input | 32 | Read word at `dataAddr`, combinational |
| dataWdata | output | 32 | Write word (register A) |
| dataWe | output | 1 | Write strobe, taken at the rising edge |
| haltValid | output | 1 | One-cycle supervisor call strobe |
| haltCode | output | 32 | Call code (register A) while `haltValid` is high |

## Verification
The A register only shows at the ports through stores and the halt code. A wrong value in A therefore appears at the next store or supervisor call, and every program in the bench ends in a call that exposes A. If the operand register is not cleared, or a prefix is mis-shifted, the value of the very next consuming instruction is wrong, so short prefix chains separate these faults within one or two bytes. A wrong pc shows at once on `fetchAddr`. Each program is therefore checked both for the cycle on which it halts and for the address it halts at, which catches branches taken on the wrong condition or to the wrong target.

// File: rtl/nib_pkg.sv
package nib_pkg;

  localparam int IMM_W = 4;
  localparam int INSN_W = 2 * IMM_W;

  typedef enum logic [3:0] {
    OP_LDAM = 4'h0, OP_LDBM = 4'h1, OP_STAM = 4'h2, OP_LDAC = 4'h3,
    OP_LDBC = 4'h4, OP_LDAP = 4'h5, OP_LDAI = 4'h6, OP_LDBI = 4'h7,
    OP_STAI = 4'h8, OP_BR   = 4'h9, OP_BRZ  = 4'hA, OP_BRN  = 4'hB,
    OP_NOP  = 4'hC, OP_OPR  = 4'hD, OP_PFIX = 4'hE, OP_NFIX = 4'hF
  } opcode_e;

  typedef enum logic [2:0] {A_KEEP, A_MEM, A_OPND, A_PCREL, A_ADD, A_SUB} aSrc_e;
  typedef enum logic [1:0] {B_KEEP, B_MEM, B_OPND} bSrc_e;
  typedef enum logic [1:0] {ADR_OPND, ADR_ABASE, ADR_BBASE} adrSrc_e;
  typedef enum logic [1:0] {PC_HOLD, PC_INC, PC_REL, PC_BREG} pcSrc_e;
  typedef enum logic [1:0] {OR_CLEAR, OR_HOLD, OR_PFIX, OR_NFIX} orSrc_e;

  typedef struct packed {
    aSrc_e   aSrc;
    bSrc_e   bSrc;
    adrSrc_e adrSrc;
    pcSrc_e  pcSrc;
    orSrc_e  orSrc;
    logic    memWe;
  } strobe_t;

endpackage

// File: rtl/nib_ctrl.sv
module nib_ctrl
  import nib_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  opcode_e           opcode,
  input  logic [DATA_W-1:0] opnd,
  input  logic              aZero,
  input  logic              aNeg,
  output strobe_t           stb,
  output logic              fetchEn,
  output logic              svcNow
);

  localparam logic [DATA_W-1:0] CODE_BRB = DATA_W'(0);
  localparam logic [DATA_W-1:0] CODE_ADD = DATA_W'(1);
  localparam logic [DATA_W-1:0] CODE_SUB = DATA_W'(2);
  localparam logic [DATA_W-1:0] CODE_SVC = DATA_W'(3);

  logic halted;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halted <= 1'b0;
    else if (svcNow) halted <= 1'b1;
  end

  assign fetchEn = !halted;

  always_comb begin
    stb = '{aSrc: A_KEEP, bSrc: B_KEEP, adrSrc: ADR_OPND,
            pcSrc: PC_INC, orSrc: OR_CLEAR, memWe: 1'b0};
    svcNow = 1'b0;
    if (halted) begin
      stb.pcSrc = PC_HOLD;
      stb.orSrc = OR_HOLD;
    end else begin
      unique case (opcode)
        OP_LDAM: stb.aSrc = A_MEM;
        OP_LDBM: stb.bSrc = B_MEM;
        OP_STAM: stb.memWe = 1'b1;
        OP_LDAC: stb.aSrc = A_OPND;
        OP_LDBC: stb.bSrc = B_OPND;
        OP_LDAP: stb.aSrc = A_PCREL;
        OP_LDAI: begin stb.aSrc = A_MEM; stb.adrSrc = ADR_ABASE; end
        OP_LDBI: begin stb.bSrc = B_MEM; stb.adrSrc = ADR_BBASE; end
        OP_STAI: begin stb.memWe = 1'b1; stb.adrSrc = ADR_BBASE; end
        OP_BR:   stb.pcSrc = PC_REL;
        OP_BRZ:  if (aZero) stb.pcSrc = PC_REL;
        OP_BRN:  if (aNeg) stb.pcSrc = PC_REL;
        OP_OPR: begin
          if (opnd == CODE_BRB) stb.pcSrc = PC_BREG;
          else if (opnd == CODE_ADD) stb.aSrc = A_ADD;
          else if (opnd == CODE_SUB) stb.aSrc = A_SUB;
          else if (opnd == CODE_SVC) begin
            svcNow = 1'b1;
            stb.pcSrc = PC_HOLD;
          end
        end
        OP_PFIX: stb.orSrc = OR_PFIX;
        OP_NFIX: stb.orSrc = OR_NFIX;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/nib_dpath.sv
module nib_dpath
  import nib_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  strobe_t           stb,
  input  logic [IMM_W-1:0]  imm,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] pcOut,
  output logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] memAddr,
  output logic [DATA_W-1:0] aOut,
  output logic              aZero,
  output logic              aNeg
);

  localparam logic [DATA_W-1:0] NEG_FILL = {DATA_W{1'b1}} << INSN_W;

  logic [DATA_W-1:0] pc, oreg, aReg, bReg;
  logic [DATA_W-1:0] pcInc, pcRel, shifted;

  assign opnd    = oreg | DATA_W'(imm);
  assign pcInc   = pc + DATA_W'(1);
  assign pcRel   = pcInc + opnd;
  assign shifted = opnd << IMM_W;

  always_comb begin
    unique case (stb.adrSrc)
      ADR_ABASE: memAddr = aReg + opnd;
      ADR_BBASE: memAddr = bReg + opnd;
      default:   memAddr = opnd;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc   <= '0;
      oreg <= '0;
      aReg <= '0;
      bReg <= '0;
    end else begin
      unique case (stb.pcSrc)
        PC_INC:  pc <= pcInc;
        PC_REL:  pc <= pcRel;
        PC_BREG: pc <= bReg;
        default: pc <= pc;
      endcase
      unique case (stb.orSrc)
        OR_PFIX: oreg <= shifted;
        OR_NFIX: oreg <= NEG_FILL | shifted;
        OR_HOLD: oreg <= oreg;
        default: oreg <= '0;
      endcase
      unique case (stb.aSrc)
        A_MEM:   aReg <= memRdata;
        A_OPND:  aReg <= opnd;
        A_PCREL: aReg <= pcRel;
        A_ADD:   aReg <= aReg + bReg;
        A_SUB:   aReg <= aReg - bReg;
        default: aReg <= aReg;
      endcase
      unique case (stb.bSrc)
        B_MEM:   bReg <= memRdata;
        B_OPND:  bReg <= opnd;
        default: bReg <= bReg;
      endcase
    end
  end

  assign pcOut = pc;
  assign aOut  = aReg;
  assign aZero = (aReg == '0);
  assign aNeg  = aReg[DATA_W-1];

endmodule

// File: rtl/nib_core.sv
module nib_core
  import nib_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              fetchEn,
  output logic [DATA_W-1:0] fetchAddr,
  input  logic [INSN_W-1:0] fetchByte,
  output logic [DATA_W-1:0] dataAddr,
  input  logic [DATA_W-1:0] dataRdata,
  output logic [DATA_W-1:0] dataWdata,
  output logic              dataWe,
  output logic              haltValid,
  output logic [DATA_W-1:0] haltCode
);

  strobe_t           stb;
  opcode_e           opcode;
  logic [DATA_W-1:0] opnd, aVal;
  logic              aZero, aNeg, svcNow;

  assign opcode = opcode_e'(fetchByte[INSN_W-1:IMM_W]);

  nib_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .opnd(opnd),
    .aZero(aZero), .aNeg(aNeg), .stb(stb), .fetchEn(fetchEn), .svcNow(svcNow)
  );

  nib_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb), .imm(fetchByte[IMM_W-1:0]),
    .memRdata(dataRdata), .pcOut(fetchAddr), .opnd(opnd),
    .memAddr(dataAddr), .aOut(aVal), .aZero(aZero), .aNeg(aNeg)
  );

  assign dataWdata = aVal;
  assign dataWe    = stb.memWe;
  assign haltValid = svcNow;
  assign haltCode  = aVal;

endmodule

// File: rtl/nib_core_chk.sv
module nib_core_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetchEn,
  input logic [DATA_W-1:0] fetchAddr,
  input logic [7:0]        fetchByte,
  input logic              dataWe,
  input logic              haltValid
);

  logic plainOp;
  assign plainOp = (fetchByte[7:4] <= 4'h8) || (fetchByte[7:4] >= 4'hE)
                   || (fetchByte[7:4] == 4'hC);

  // R10: the halt strobe lasts a single cycle
  a_r10_halt_single: assert property (@(posedge clk) disable iff (!rst_n)
    haltValid |=> !haltValid);

  // R11: a supervisor call stops fetching on the next cycle
  a_r11_stop_after_call: assert property (@(posedge clk) disable iff (!rst_n)
    haltValid |=> !fetchEn);

  // R11: once stopped, the pc is frozen and stays stopped
  a_r11_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchEn |=> (!fetchEn && $stable(fetchAddr)));

  // R11: no writes or halt strobes while stopped
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !fetchEn |-> (!dataWe && !haltValid));

  // R12: writes only on store opcodes
  a_r12_store_only: assert property (@(posedge clk) disable iff (!rst_n)
    dataWe |-> (fetchByte[7:4] == 4'h2 || fetchByte[7:4] == 4'h8));

  // R2: non-branching instructions step the pc by one byte
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchEn && plainOp) |=> (fetchAddr == $past(fetchAddr) + DATA_W'(1)));

endmodule

bind nib_core nib_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fetchEn(fetchEn), .fetchAddr(fetchAddr),
  .fetchByte(fetchByte), .dataWe(dataWe), .haltValid(haltValid)
);

// File: tb/nib_core_tb.sv
`timescale 1ns/1ps
module nib_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetchEn, dataWe, haltValid;
  logic [31:0] fetchAddr, dataAddr, dataRdata, dataWdata, haltCode;
  logic [7:0]  fetchByte;

  logic [7:0]  imem [256];
  logic [31:0] dmem [64];

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  nib_core u_dut (
    .clk(clk), .rst_n(rst_n), .fetchEn(fetchEn), .fetchAddr(fetchAddr),
    .fetchByte(fetchByte), .dataAddr(dataAddr), .dataRdata(dataRdata),
    .dataWdata(dataWdata), .dataWe(dataWe), .haltValid(haltValid),
    .haltCode(haltCode)
  );

  assign fetchByte = imem[fetchAddr[7:0]];
  assign dataRdata = dmem[dataAddr[5:0]];

  always @(posedge clk) if (dataWe) dmem[dataAddr[5:0]] <= dataWdata;

  typedef struct packed {
    logic [63:0] prog;   // byte 0 in bits 7:0
    logic [31:0] code;
    logic [7:0]  ncyc;
    logic [7:0]  hpc;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VEC [NVEC] = '{
    '{64'h0000_0000_00D3_30E1, 32'h0000_0010, 8'd3, 8'd2}, // R3 single prefix
    '{64'h0000_0000_D330_EFE1, 32'h0000_01F0, 8'd4, 8'd3}, // R3 chained
    '{64'h0000_0000_00D3_3FFF, 32'hFFFF_FFFF, 8'd3, 8'd2}, // R3 negative
    '{64'h0000_0000_D330_E0FE, 32'hFFFF_FE00, 8'd4, 8'd3}, // R3 negative scaled
    '{64'h0000_0000_D3D1_4937, 32'h0000_0010, 8'd4, 8'd3}, // R9 add
    '{64'h0000_0000_D3D2_4533, 32'hFFFF_FFFE, 8'd4, 8'd3}, // R9 sub
    '{64'h0000_0000_0000_D352, 32'h0000_0003, 8'd2, 8'd1}, // R5 pc-relative
    '{64'h0000_0000_D335_3F91, 32'h0000_0005, 8'd3, 8'd3}, // R8 branch
    '{64'h0000_0000_D339_A130, 32'h0000_0000, 8'd3, 8'd3}, // R8 zero taken
    '{64'h0000_0000_D339_A132, 32'h0000_0009, 8'd4, 8'd3}, // R8 zero not taken
    '{64'h0000_00D3_35B1_3FFF, 32'hFFFF_FFFF, 8'd4, 8'd4}, // R8 negative taken
    '{64'h0000_0000_D337_B135, 32'h0000_0007, 8'd4, 8'd3}, // R8 negative not taken
    '{64'h0000_D336_D331_D044, 32'h0000_0006, 8'd4, 8'd5}, // R9 absolute branch
    '{64'h0000_D3D1_3112_2239, 32'h0000_000A, 8'd6, 8'd5}, // R6 store/load
    '{64'hD3D1_7163_3081_3742, 32'h0000_000E, 8'd8, 8'd7}, // R7 indexed
    '{64'h0000_00D3_D241_30E1, 32'h0000_000F, 8'd5, 8'd4}, // R4 operand cleared
    '{64'h0000_0000_D3D5_C733, 32'h0000_0003, 8'd4, 8'd3}, // R9 no-ops
    '{64'h0000_00D3_D1E1_4133, 32'h0000_0003, 8'd5, 8'd4}, // R9 prefixed code
    '{64'h0000_9CFF_37D3_0092, 32'h0000_0007, 8'd5, 8'd2}  // R8 backward
  };

  function automatic string tagOf(int i);
    if (i <= 3) return "R3";
    if (i == 6) return "R5";
    if (i == 13) return "R6";
    if (i == 14) return "R7";
    if (i == 15) return "R4";
    if ((i >= 7 && i <= 11) || i == 18) return "R8";
    return "R9";
  endfunction

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic loadProg(input logic [63:0] prog);
    for (int i = 0; i < 256; i++) imem[i] = 8'h00;
    for (int i = 0; i < 64; i++) dmem[i] = 32'h0;
    for (int i = 0; i < 8; i++) imem[i] = prog[8*i +: 8];
  endtask

  task automatic runToHalt(output int cyc, output logic [31:0] code,
                           output logic [31:0] hpc, output bit seen);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    seen = 0; cyc = 0; code = 'x; hpc = 'x;
    for (int k = 0; k < 64; k++) begin
      #1;
      cyc++;
      if (haltValid) begin
        seen = 1; code = haltCode; hpc = fetchAddr;
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        total++; bad++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        finishRun();
      end
    end
  end

  initial begin
    int cyc;
    logic [31:0] code, hpc;
    bit seen;

    // R1: reset state
    loadProg(64'h0000_0000_0000_D331);
    rst_n = 1'b0;
    #1;
    repeat (2) @(negedge clk);
    chk("R1", "fetchAddr in reset", fetchAddr, 32'h0);
    chk("R1", "fetchEn in reset", {31'b0, fetchEn}, 32'h1);
    chk("R1", "dataWe in reset", {31'b0, dataWe}, 32'h0);
    // R1: first instruction from byte 0; A starts at zero so LDAC 1 -> code 1
    runToHalt(cyc, code, hpc, seen);
    chk("R1", "start halt code", code, 32'h1);
    chk("R1", "start halt pc", hpc, 32'h1);

    // table of programs
    for (int v = 0; v < NVEC; v++) begin
      loadProg(VEC[v].prog);
      runToHalt(cyc, code, hpc, seen);
      chk(tagOf(v), $sformatf("vec %0d halt seen", v), {31'b0, seen}, 32'h1);
      chk(tagOf(v), $sformatf("vec %0d halt code", v), code, VEC[v].code);
      chk("R2", $sformatf("vec %0d cycles", v), cyc, 32'(VEC[v].ncyc));
      chk(tagOf(v), $sformatf("vec %0d halt pc", v), hpc, 32'(VEC[v].hpc));
    end

    // R6: word addressing on the data port, absolute read
    loadProg(64'h0000_0000_0000_D301);
    dmem[1] = 32'h1234_5678;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R6", "read address", dataAddr, 32'h1);
    runToHalt(cyc, code, hpc, seen);
    chk("R6", "word read value", code, 32'h1234_5678);

    // R12: store strobe, address and data at the port
    loadProg(64'h0000_0000_00D3_2239);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R12", "no write on constant load", {31'b0, dataWe}, 32'h0);
    @(negedge clk); #1;
    chk("R12", "write strobe", {31'b0, dataWe}, 32'h1);
    chk("R6", "store address", dataAddr, 32'h2);
    chk("R12", "store data", dataWdata, 32'h9);
    @(negedge clk); #1;
    chk("R12", "stored word", dmem[2], 32'h9);

    // R10 / R11: single strobe and frozen core after the call
    loadProg(VEC[13].prog);
    runToHalt(cyc, code, hpc, seen);
    @(negedge clk); #1;
    chk("R10", "strobe drops", {31'b0, haltValid}, 32'h0);
    for (int k = 0; k < 5; k++) begin
      chk("R11", "fetchEn low", {31'b0, fetchEn}, 32'h0);
      chk("R11", "pc frozen", fetchAddr, 32'h5);
      chk("R11", "no write", {31'b0, dataWe}, 32'h0);
      chk("R11", "no strobe", {31'b0, haltValid}, 32'h0);
      @(negedge clk); #1;
    end
    chk("R11", "memory untouched", dmem[2], 32'h9);
    // R1: reset restarts the core
    rst_n = 1'b0;
    #1;
    chk("R1", "restart pc", fetchAddr, 32'h0);
    chk("R1", "restart fetchEn", {31'b0, fetchEn}, 32'h1);
    rst_n = 1'b1;

    finishRun();
  end

endmodule